// File: doc/BRIEF.md
# Clock Master Failover Configuration Bank

This block holds the configuration of a node on a shared timeslot backplane: whether the node drives the backplane clock, whether it is standing by to take over that role, which of two redundant bus copies it listens to, whether it runs in an isolated self-test loopback, and the framing rates of the backplane and the local bus. A host reaches the two configuration bytes indirectly. It first loads an index register and then reads or writes the byte that the index selects through a data port.

The main job of the block is automatic failover. A node that is armed, and whose debounce enable is on, takes clock mastership by itself once the clock-fail signal rises. A synchronizer brings that signal into the master clock domain first. The host can also drop mastership with a terminate command. This command clears the mastership bit asynchronously, so it still works when the master clock has stopped. The outputs are a backplane drive enable, a loopback control, the selected bus copy, timeslot counts decoded from the framing fields, and a sanitized clock-frequency code.

Top module: `clkmaster_cfg`

## Requirements
- R1: After reset, byte 0 reads 08h and byte 1 reads 00h. The index register is 00h, `bus_drive_en` is 0 and `loopback_en` is 1.
- R2: A pulse on `idx_we` loads `wdata` into the index register. A pulse on `dat_we` writes `wdata` into byte 0 when the index is 00h and into byte 1 when the index is 01h. For any other index, writes change nothing and `rdata` reads 00h. `rdata` always shows the byte that the current index selects.
- R3: The byte 0 layout is: bit 0 master enable, bit 1 arm, bit 2 alternate-bus select, bit 3 diagnostic mode, bits 5:4 backplane framing, bits 7:6 local framing. A host write to bit 0 takes effect at the next master clock edge.
- R4: When arm is 1, `dbnc_en` is 1 and `clk_fail` is high, the master enable sets by itself. `bus_drive_en` rises at the third clock edge after `clk_fail` rises, which is within the 4-cycle limit.
- R5: When `dbnc_en` is 0, arm has no effect and `clk_fail` never sets the master enable.
- R6: The terminate command is `term` high while the index is 00h and `wdata[0]` is 0. It clears the master enable asynchronously, with no clock edge needed. If the index is not 00h, or `wdata[0]` is 1, `term` has no effect.
- R7: `bus_drive_en` equals master enable AND NOT diagnostic mode. `loopback_en` equals the diagnostic mode bit.
- R8: Framing code 00 or 01 decodes to 32 timeslots, 10 to 64 and 11 to 128. The backplane field gives `bus_slots` and the local field gives `loc_slots`.
- R9: Byte 1 bits 2:0 are the master clock frequency code, 000 for 2.048 MHz through 101 for 65.536 MHz. Byte 1 reads back exactly as written, including the reserved codes 110 and 111. `mclk_sel` gives the code, with the reserved codes replaced by 000.
- R10: If a host write of 0 to master enable lands in the same cycle as an automatic set, the master enable ends up 1.
- R11: `alt_sel` follows byte 0 bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Load index register from wdata |
| dat_we | input | 1 | Write the indexed byte from wdata |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Byte selected by the index |
| term | input | 1 | Terminate command strobe (asynchronous effect) |
| clk_fail | input | 1 | Raw clock-failure indication |
| dbnc_en | input | 1 | Enables automatic takeover on clock failure |
| bus_drive_en | output | 1 | Drive the backplane clock and data |
| loopback_en | output | 1 | Internal loopback, drivers isolated |
| alt_sel | output | 1 | Select the alternate backplane copy |
| bus_slots | output | 8 | Backplane timeslots per frame |
| loc_slots | output | 8 | Local bus timeslots per frame |
| mclk_sel | output | 3 | Master clock frequency code, reserved codes mapped to 000 |

## Verification
The assertions assume that the host never pulses `idx_we` and `dat_we` in the same cycle. They also assume that `term` changes only between clock edges and is held across at least one edge, so that a clocked check sees the asynchronous clear already settled. The stimulus keeps to this by driving every host strobe at the falling edge, one strobe per cycle. It raises `term` only while the clock is stopped low, or half a cycle ahead of a rising edge. During the random phase, `clk_fail` and `dbnc_en` stay low, so the bench model's expected values follow from host writes alone. The failover cases are driven as directed sequences.

// File: rtl/cmcfg_pkg.sv
package cmcfg_pkg;

    localparam int BYTE_W  = 8;
    localparam int FREQ_W  = 3;
    localparam int FRM_W   = 2;

    localparam logic [BYTE_W-1:0] IDX_CTRL = 8'h00;
    localparam logic [BYTE_W-1:0] IDX_CLK  = 8'h01;

    typedef struct packed {
        logic [BYTE_W-1:0] idx;
        logic              arm;
        logic              alt;
        logic              diag;
        logic [FRM_W-1:0]  bus_fm;
        logic [FRM_W-1:0]  loc_fm;
        logic [BYTE_W-1:0] clk_byte;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        idx:      '0,
        arm:      1'b0,
        alt:      1'b0,
        diag:     1'b1,
        bus_fm:   '0,
        loc_fm:   '0,
        clk_byte: '0
    };

endpackage

// File: rtl/cmcfg_sync.sv
module cmcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/cmcfg_frame_dec.sv
module cmcfg_frame_dec #(
    parameter int CODE_W  = 2,
    parameter int SLOTS_W = 8,
    parameter int BASE_LG = 5
) (
    input  logic [CODE_W-1:0]  code,
    output logic [SLOTS_W-1:0] slots
);
    localparam logic [SLOTS_W-1:0] ONE = SLOTS_W'(1);

    always_comb begin
        if (code[CODE_W-1]) slots = ONE << (BASE_LG + 1 + int'(code[0]));
        else                slots = ONE << BASE_LG;
    end
endmodule

// File: rtl/cmcfg_freq_dec.sv
module cmcfg_freq_dec #(
    parameter int FREQ_W   = 3,
    parameter int MAX_CODE = 5
) (
    input  logic [FREQ_W-1:0] raw,
    output logic [FREQ_W-1:0] eff
);
    always_comb begin
        if (raw > FREQ_W'(MAX_CODE)) eff = '0;
        else                         eff = raw;
    end
endmodule

// File: rtl/clkmaster_cfg.sv
module clkmaster_cfg
    import cmcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SLOTS_W     = 8,
    parameter int SLOT_LG     = 5,
    parameter int FREQ_MAX    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              dat_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              term,
    input  logic              clk_fail,
    input  logic              dbnc_en,
    output logic              bus_drive_en,
    output logic              loopback_en,
    output logic              alt_sel,
    output logic [SLOTS_W-1:0] bus_slots,
    output logic [SLOTS_W-1:0] loc_slots,
    output logic [FREQ_W-1:0]  mclk_sel
);
    cfg_t cfg_d, cfg_q;
    logic master_d, master_q;
    logic fail_sync;
    logic term_clr;
    logic auto_set;
    logic [BYTE_W-1:0] idx_q;
    logic arm_q;

    cmcfg_sync #(.STAGES(SYNC_STAGES)) u_fail_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (clk_fail),
        .q_out (fail_sync)
    );

    assign idx_q    = cfg_q.idx;
    assign arm_q    = cfg_q.arm;
    assign auto_set = arm_q & dbnc_en & fail_sync;
    assign term_clr = term & (idx_q == IDX_CTRL) & ~wdata[0];

    always_comb begin
        cfg_d    = cfg_q;
        master_d = master_q;
        if (idx_we) begin
            cfg_d.idx = wdata;
        end
        if (dat_we) begin
            if (idx_q == IDX_CTRL) begin
                master_d      = wdata[0];
                cfg_d.arm     = wdata[1];
                cfg_d.alt     = wdata[2];
                cfg_d.diag    = wdata[3];
                cfg_d.bus_fm  = wdata[5:4];
                cfg_d.loc_fm  = wdata[7:6];
            end else if (idx_q == IDX_CLK) begin
                cfg_d.clk_byte = wdata;
            end
        end
        if (auto_set) begin
            master_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    always_ff @(posedge clk or negedge rst_n or posedge term_clr) begin
        if (!rst_n)        master_q <= 1'b0;
        else if (term_clr) master_q <= 1'b0;
        else               master_q <= master_d;
    end

    always_comb begin
        case (idx_q)
            IDX_CTRL: rdata = {cfg_q.loc_fm, cfg_q.bus_fm, cfg_q.diag,
                               cfg_q.alt, cfg_q.arm, master_q};
            IDX_CLK:  rdata = cfg_q.clk_byte;
            default:  rdata = '0;
        endcase
    end

    assign bus_drive_en = master_q & ~cfg_q.diag;
    assign loopback_en  = cfg_q.diag;
    assign alt_sel      = cfg_q.alt;

    cmcfg_frame_dec #(.CODE_W(FRM_W), .SLOTS_W(SLOTS_W), .BASE_LG(SLOT_LG)) u_bus_dec (
        .code  (cfg_q.bus_fm),
        .slots (bus_slots)
    );

    cmcfg_frame_dec #(.CODE_W(FRM_W), .SLOTS_W(SLOTS_W), .BASE_LG(SLOT_LG)) u_loc_dec (
        .code  (cfg_q.loc_fm),
        .slots (loc_slots)
    );

    cmcfg_freq_dec #(.FREQ_W(FREQ_W), .MAX_CODE(FREQ_MAX)) u_freq_dec (
        .raw (cfg_q.clk_byte[FREQ_W-1:0]),
        .eff (mclk_sel)
    );
endmodule

// File: rtl/clkmaster_cfg_chk.sv
module clkmaster_cfg_chk #(
    parameter int SLOTS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               idx_we,
    input logic               dat_we,
    input logic [7:0]         wdata,
    input logic               term,
    input logic               dbnc_en,
    input logic               fail_sync,
    input logic               arm_q,
    input logic               master_q,
    input logic [7:0]         idx_q,
    input logic               bus_drive_en,
    input logic               loopback_en,
    input logic [SLOTS_W-1:0] bus_slots,
    input logic [SLOTS_W-1:0] loc_slots,
    input logic [2:0]         mclk_sel
);
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> idx_q == $past(wdata)); // R2

    AST_AUTO_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n || term)
        (fail_sync && arm_q && dbnc_en) |=> master_q); // R4

    AST_NO_DEBOUNCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbnc_en && !master_q && !dat_we) |=> !master_q); // R5

    AST_TERM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (term && idx_q == 8'h00 && !wdata[0]) |-> !master_q); // R6

    AST_DRIVE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_en |-> !loopback_en); // R7

    AST_SLOTS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(bus_slots) == 1) && ($countones(loc_slots) == 1)); // R8

    AST_FREQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_sel <= 3'd5); // R9
endmodule

bind clkmaster_cfg clkmaster_cfg_chk #(.SLOTS_W(SLOTS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_we       (idx_we),
    .dat_we       (dat_we),
    .wdata        (wdata),
    .term         (term),
    .dbnc_en      (dbnc_en),
    .fail_sync    (fail_sync),
    .arm_q        (arm_q),
    .master_q     (master_q),
    .idx_q        (idx_q),
    .bus_drive_en (bus_drive_en),
    .loopback_en  (loopback_en),
    .bus_slots    (bus_slots),
    .loc_slots    (loc_slots),
    .mclk_sel     (mclk_sel)
);

// File: tb/tb_clkmaster_cfg.sv
`timescale 1ns/1ps
module tb_clkmaster_cfg;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0, dat_we = 1'b0, term = 1'b0;
    logic       clk_fail = 1'b0, dbnc_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, bus_slots, loc_slots;
    logic [2:0] mclk_sel;
    logic       bus_drive_en, loopback_en, alt_sel;
    int checks = 0, errors = 0;
    bit done = 0;

    clkmaster_cfg dut (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
        .wdata(wdata), .rdata(rdata), .term(term), .clk_fail(clk_fail),
        .dbnc_en(dbnc_en), .bus_drive_en(bus_drive_en), .loopback_en(loopback_en),
        .alt_sel(alt_sel), .bus_slots(bus_slots), .loc_slots(loc_slots),
        .mclk_sel(mclk_sel)
    );

    always #2.5 if (clk_run) clk = ~clk;

    function automatic logic [7:0] slots_of(input logic [1:0] c);
        return c[1] ? (c[0] ? 8'd128 : 8'd64) : 8'd32;
    endfunction

    function automatic logic [2:0] freq_of(input logic [2:0] c);
        return (c > 3'd5) ? 3'd0 : c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_idx(input logic [7:0] v);
        @(negedge clk); wdata = v; idx_we = 1'b1;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); wdata = v; dat_we = 1'b1;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic check_b0(input string req, input logic [7:0] b);
        chk(req, rdata, b);
        chk(req, bus_drive_en, b[0] & ~b[3]);
        chk(req, loopback_en, b[3]);
        chk(req, alt_sel, b[2]);
        chk(req, bus_slots, slots_of(b[5:4]));
        chk(req, loc_slots, slots_of(b[7:6]));
    endtask

    initial begin
        logic [7:0] b0, b1;
        void'($urandom(32'h5eed_c10c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", rdata, 8'h08);
        chk("R1", bus_drive_en, 1'b0);
        chk("R1", loopback_en, 1'b1);
        wr_idx(8'h01);
        chk("R1", rdata, 8'h00);
        chk("R9", mclk_sel, 3'd0);

        // R2 unused index: reads zero, writes ignored
        wr_idx(8'h07);
        chk("R2", rdata, 8'h00);
        wr_dat(8'hFF);
        chk("R2", rdata, 8'h00);
        wr_idx(8'h00);
        chk("R2", rdata, 8'h08);
        wr_idx(8'h01);
        chk("R2", rdata, 8'h00);

        // R9 reserved codes read back, decode to 000
        wr_dat(8'hA6);
        chk("R9", rdata, 8'hA6);
        chk("R9", mclk_sel, 3'd0);
        wr_dat(8'h07);
        chk("R9", mclk_sel, 3'd0);
        wr_dat(8'h05);
        chk("R9", mclk_sel, 3'd5);
        b1 = 8'h05;

        // Random phase: R2 R3 R7 R8 R9 R11
        b0 = 8'h08;
        for (int i = 0; i < 200; i++) begin
            logic [7:0] v;
            logic sel;
            v = 8'($urandom);
            sel = 1'($urandom);
            wr_idx({7'd0, sel});
            wr_dat(v);
            if (sel) begin
                b1 = v;
                chk("R9", rdata, b1);
                chk("R9", mclk_sel, freq_of(b1[2:0]));
            end else begin
                b0 = v;
                check_b0("R3 R7 R8 R11", b0);
            end
        end

        // R5 no debounce enable: arm has no effect
        wr_idx(8'h00);
        wr_dat(8'h02);
        dbnc_en = 1'b0;
        clk_fail = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5", bus_drive_en, 1'b0);
        chk("R5", rdata, 8'h02);
        clk_fail = 1'b0;
        repeat (3) @(negedge clk);

        // R4 takeover latency
        dbnc_en = 1'b1;
        @(negedge clk);
        clk_fail = 1'b1;
        @(negedge clk);
        chk("R4", bus_drive_en, 1'b0);
        @(negedge clk);
        chk("R4", bus_drive_en, 1'b0);
        @(negedge clk);
        chk("R4", bus_drive_en, 1'b1);
        chk("R4", rdata, 8'h03);

        // R10 host write of 0 loses to automatic set
        wr_dat(8'h02);
        chk("R10", rdata, 8'h03);
        chk("R10", bus_drive_en, 1'b1);

        // R6 terminate with clock stopped
        clk_fail = 1'b0;
        dbnc_en = 1'b0;
        repeat (3) @(negedge clk);
        wr_dat(8'h01);
        chk("R3", bus_drive_en, 1'b1);
        @(negedge clk);
        clk_run = 1'b0;
        #10;
        wdata = 8'h00;
        term = 1'b1;
        #5;
        chk("R6", bus_drive_en, 1'b0);
        chk("R6", rdata, 8'h00);
        term = 1'b0;
        #5;
        clk_run = 1'b1;
        @(negedge clk);

        // R6 terminate ignored when data bit 0 is 1
        wr_dat(8'h01);
        @(negedge clk);
        wdata = 8'h01;
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R6", bus_drive_en, 1'b1);

        // R6 terminate ignored at index 01h
        wr_idx(8'h01);
        @(negedge clk);
        wdata = 8'h00;
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R6", bus_drive_en, 1'b1);

        // R7 diagnostic mode gates the drivers
        wr_idx(8'h00);
        wr_dat(8'h09);
        check_b0("R7", 8'h09);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule